// File: doc/BRIEF.md
# Press-and-Release Single-Pulse Generator

This block turns a mechanical pushbutton that reads low while pressed into a strobe one clock cycle wide. Each complete gesture produces exactly one strobe: the key goes low, stays low for any length of time, and then comes back high. The strobe is raised only after the key has come back high, so a key that is held down produces nothing, however long it is held. The strobe is meant to serve as a step enable for a downstream state machine that should advance once per button gesture rather than once per clock.

The raw key first passes through a chain of synchronizer flops. A small state machine then watches the synchronized level. Reset clears the block asynchronously, and its release is synchronized to the clock. After a reset, the machine stays in a wake-up state until it sees the key high. Because of this, a key that is already down when reset lifts cannot count as a press. Timer-based contact debouncing is not part of the block. The key is assumed to be clean or filtered before it arrives.

Top module: `btn_press_pulse`

## Requirements
- R1: Every complete press-then-release of the key produces exactly one `press_pulse`, and that pulse is high for exactly one clock cycle.
- R2: The key is active low. `key_n` = 0 means pressed and `key_n` = 1 means released. A key that stays at 1 produces no pulse.
- R3: While the key is held at 0, no pulse is produced, however long it is held. The pulse comes only after the key returns to 1.
- R4: With the default two synchronizer stages, the pulse is high in the cycle that follows the third rising edge after `key_n` rises. In general, it follows the rising edge numbered SYNC_STAGES+1.
- R5: If the key is already 0 when reset is released, no pulse is produced when that key is released. A pulse comes only from a later press followed by a release.
- R6: Driving `rst_n` low forces `press_pulse` to 0 at once, without waiting for a clock edge. A press that is interrupted by reset never produces a pulse.
- R7: Two press-release gestures separated by a single clock cycle of released key produce two separate pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; release synchronized inside |
| key_n | input | 1 | Raw pushbutton level, 0 while pressed |
| press_pulse | output | 1 | One-cycle strobe per completed press-release |

## Verification
Two situations are hard to produce from the ports.

The first is a key that is already down at the moment reset lifts. To reach it, the bench lowers `key_n` before it asserts `rst_n` and keeps the key down through the synchronized reset release. It then releases the key and confirms that no strobe appears. Only after that does it make a fresh press.

The second is the tightest back-to-back case. Here `key_n` is high for exactly one cycle between two presses, so the machine must leave its fire state directly for the held state. The bench drives that single high cycle on a falling edge and counts two separate strobes.

// File: rtl/btn_pulse_pkg.sv
package btn_pulse_pkg;

  // WAKE : after reset, key not yet seen released
  // IDLE : armed, waiting for the key to go low
  // HELD : key low, waiting for it to return high
  // FIRE : strobe cycle
  typedef enum logic [1:0] {
    ST_WAKE = 2'd0,
    ST_IDLE = 2'd1,
    ST_HELD = 2'd2,
    ST_FIRE = 2'd3
  } press_state_e;

endpackage

// File: rtl/btn_rst_sync.sv
module btn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = chain_q[LAST];

endmodule

// File: rtl/btn_key_sync.sv
module btn_key_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RESET_VAL;
        else        stage_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
        else        stage_q <= {stage_q[LAST-1:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[LAST];

endmodule

// File: rtl/btn_press_fsm.sv
module btn_press_fsm
  import btn_pulse_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_level,
  output press_state_e state_o,
  output logic         fire_o
);

  press_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAKE: if (key_level)  state_d = ST_IDLE;
      ST_IDLE: if (!key_level) state_d = ST_HELD;
      ST_HELD: if (key_level)  state_d = ST_FIRE;
      ST_FIRE: state_d = key_level ? ST_IDLE : ST_HELD;
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAKE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign fire_o  = (state_q == ST_FIRE);

endmodule

// File: rtl/btn_press_pulse.sv
module btn_press_pulse
  import btn_pulse_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_n,
  output logic press_pulse
);

  logic         rst_int_n;
  logic         key_sync;
  logic         fire;
  press_state_e fsm_state;

  btn_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  // Reset value 0 looks like "pressed": WAKE then waits for a real release.
  btn_key_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_key_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (key_n),
    .dout  (key_sync)
  );

  btn_press_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .key_level (key_sync),
    .state_o   (fsm_state),
    .fire_o    (fire)
  );

  assign press_pulse = fire;

endmodule

// File: rtl/btn_press_pulse_chk.sv
module btn_press_pulse_chk
  import btn_pulse_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         key_s,
  input press_state_e state,
  input logic         pulse
);

  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  p_pulse_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(key_s));

  p_fire_from_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIRE) |-> ($past(state) == ST_HELD));

  p_reset_quiet_r6: assert property (@(posedge clk)
    !rst_n |-> !pulse);

endmodule

bind btn_press_pulse btn_press_pulse_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .key_s (key_sync),
  .state (fsm_state),
  .pulse (press_pulse)
);

// File: tb/btn_press_pulse_test.sv
module btn_press_pulse_test;

  localparam int LAT  = 3;   // R4 with SYNC_STAGES = 2
  localparam int NVEC = 7;
  // columns: hold cycles low, extra high cycles after release
  localparam int VEC [0:NVEC-1][0:1] = '{
    '{1, 2}, '{2, 1}, '{3, 5}, '{7, 0}, '{40, 3}, '{250, 8}, '{1, 0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic key_n;
  logic press_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  int pulses = 0;
  int wide   = 0;
  logic prev_pulse = 1'b0;

  always #4 clk = ~clk;

  btn_press_pulse uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_n       (key_n),
    .press_pulse (press_pulse)
  );

  always @(negedge clk) begin
    if (press_pulse === 1'b1) pulses++;
    if (press_pulse === 1'b1 && prev_pulse === 1'b1) wide++;
    prev_pulse <= press_pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // press for hold cycles, release, return latency to pulse (0 = none)
  task automatic press_release(input int hold, output int lat);
    lat = 0;
    key_n = 1'b0;
    idle(hold);
    key_n = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (press_pulse === 1'b1 && lat == 0) lat = i;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    int lat;
    rst_n = 1'b0;
    key_n = 1'b1;
    idle(3);
    check("R6 pulse low in reset", int'(press_pulse), 0);
    rst_n = 1'b1;
    idle(50);
    check("R2 released key gives no pulse", pulses, 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      p0 = pulses;
      press_release(VEC[v][0], lat);
      idle(VEC[v][1]);
      check("R1 one pulse per gesture", pulses - p0, 1);
      check("R4 latency after release", lat, LAT);
    end
    check("R1 pulse width one cycle", wide, 0);

    // R3: long hold
    p0 = pulses;
    key_n = 1'b0;
    idle(1500);
    check("R3 no pulse while held", pulses - p0, 0);
    key_n = 1'b1;
    idle(10);
    check("R3 pulse after release", pulses - p0, 1);

    // R7: single-cycle high gap between presses
    p0 = pulses;
    key_n = 1'b0; idle(3);
    key_n = 1'b1; idle(1);
    key_n = 1'b0; idle(3);
    key_n = 1'b1; idle(10);
    check("R7 two pulses back to back", pulses - p0, 2);
    check("R7 pulses stay one cycle", wide, 0);

    // R5: key low across reset release
    p0 = pulses;
    key_n = 1'b0;
    idle(2);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(20);
    key_n = 1'b1;
    idle(20);
    check("R5 no pulse for key held over reset", pulses - p0, 0);
    press_release(4, lat);
    check("R5 fresh gesture pulses", pulses - p0, 1);

    // R6: reset in the middle of a press, asserted off-edge
    p0 = pulses;
    key_n = 1'b0;
    idle(5);
    #2 rst_n = 1'b0;
    #1 check("R6 async clear", int'(press_pulse), 0);
    idle(1);
    key_n = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(20);
    check("R6 interrupted press gives no pulse", pulses - p0, 0);
    press_release(2, lat);
    check("R6 operation resumes after reset", pulses - p0, 1);

    finish_run();
  end

endmodule